// File: doc/BRIEF.md
# Nested Trap Entry Sequencer

This block performs every state change a processor core makes when it takes a trap and trap levels can nest. A trap request carries a 9-bit trap type and a snapshot of the core state: current pc and next pc, condition codes, address-space identifier and the count of saveable windows. In the same cycle the block raises the trap level and stores a record for the new level. It rewrites the processor-state word, moves the register-window pointer where the trap class calls for it, and forms the new vector address from the trap base register.

The block owns the trap level, the processor-state word, the window pointer, the trap base register and a stack of saved records with one entry per level. The record of the current level is always on the outputs. If traps keep arriving, the level climbs. The trap that reaches the maximum level also puts the core into a degraded "red" condition. Any trap requested once the maximum level is reached puts the block into a sticky error condition that only reset clears.

Top module: `trap_entry_seq`

## Requirements
- R1: Reset leaves the following values:
  - `tl` = 0, `pstate` = 0, `cwp` = 0;
  - `err` and `done` low;
  - `tvec_pc` = TBA_BASE and `tvec_npc` = TBA_BASE+4;
  - the `ts_*` record outputs all zero.
- R2: A request sampled while `tl` < MAXTL-1 and `err` is low raises `tl` by one. In that case `done` is high for exactly the one cycle after the sampling edge. `done` is low in every other cycle.
- R3: A request sampled while `tl` = MAXTL-1 sets the red bit (`pstate` bit 5) and raises `tl` to MAXTL.
- R4: A request sampled while `tl` = MAXTL sets `err` and changes nothing else, and `done` stays low. While `err` is high, later requests change nothing, and `err` stays high until reset.
- R5: The saved state word of the new level is built as follows:
  - bits 39:32 hold `ccr`;
  - bits 31:24 hold `asi`;
  - bits 19:8 hold the pre-trap `pstate` masked with 0xF3F, with the red bit of R3 already applied;
  - bits 7:0 hold the pre-trap `cwp`;
  - all other bits are zero.
- R6: The saved pc, next pc and trap type of the new level are `cur_pc`, `cur_npc` and `req_tt`. The record of the current level always appears on `ts_state`, `ts_pc`, `ts_npc` and `ts_tt`.
- R7: Every accepted trap clears the three global-set bits of `pstate` (bits 0, 10 and 11) and then sets exactly one of them:
  - bit 11 for trap type 0x060 (interrupt vector);
  - bit 10 for the memory-management types 0x008, 0x030 and 0x064 through 0x06F;
  - bit 0 for every other type.
- R8: Every accepted trap sets `pstate` bit 2 (privileged) and bit 4 (FPU enable).
- R9: The window pointer moves according to the trap type, all modulo NWIN:
  - type 0x024 decrements `cwp` by 1;
  - a type with bits 8:6 = 010 subtracts `cansave`+2;
  - a type with bits 8:6 = 011 increments `cwp` by 1;
  - any other type leaves `cwp` unchanged.
  - `cansave` is below NWIN.
- R10: After an accepted trap, `tvec_pc` is TBA_BASE with bits 14:0 replaced:
  - bit 14 is (new `tl` > 1);
  - bits 13:5 are `req_tt`;
  - bits 4:0 are zero.
  - `tvec_npc` is `tvec_pc`+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Trap request strobe |
| req_tt | input | 9 | Trap type |
| cur_pc | input | AW | pc at the trap |
| cur_npc | input | AW | Next pc at the trap |
| ccr | input | 8 | Condition codes to save |
| asi | input | 8 | Address-space identifier to save |
| cansave | input | CWPW | Saveable window count used by spill traps |
| done | output | 1 | One-cycle pulse after an accepted trap |
| err | output | 1 | Sticky error condition |
| tl | output | TLW | Current trap level |
| pstate | output | 12 | Processor-state word |
| cwp | output | CWPW | Current window pointer |
| tvec_pc | output | AW | Trap vector pc |
| tvec_npc | output | AW | Trap vector next pc |
| ts_state | output | 40 | Saved state word of the current level |
| ts_pc | output | AW | Saved pc of the current level |
| ts_npc | output | AW | Saved next pc of the current level |
| ts_tt | output | 9 | Saved trap type of the current level |

## Verification
The assertions check several properties on every cycle:
- each `done` pulse goes with a single-step level increase;
- the privileged, FPU-enable and one-hot global-set bits follow every accepted trap;
- the red bit is set on entry to the top level;
- the vector address carries the saved trap type;
- the error condition freezes all state.

The exact packing of the saved state word, the modular window arithmetic for spill and fill with different `cansave` values, and the wrap of the window pointer below zero are shown only by the bench scenarios. The same holds for the choice of vector bit 14 by level and for the ignoring of requests after an error. The bench compares these against its reference model.

// File: rtl/trap_entry_seq.sv
`timescale 1ns/1ps
module trap_entry_seq #(
  parameter int AW = 64,
  parameter int NWIN = 8,
  parameter int MAXTL = 6,
  parameter logic [AW-1:0] TBA_BASE = 'h40_0000,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int TLW = $clog2(MAXTL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [8:0]      req_tt,
  input  logic [AW-1:0]   cur_pc,
  input  logic [AW-1:0]   cur_npc,
  input  logic [7:0]      ccr,
  input  logic [7:0]      asi,
  input  logic [CWPW-1:0] cansave,
  output logic            done,
  output logic            err,
  output logic [TLW-1:0]  tl,
  output logic [11:0]     pstate,
  output logic [CWPW-1:0] cwp,
  output logic [AW-1:0]   tvec_pc,
  output logic [AW-1:0]   tvec_npc,
  output logic [39:0]     ts_state,
  output logic [AW-1:0]   ts_pc,
  output logic [AW-1:0]   ts_npc,
  output logic [8:0]      ts_tt
);
  localparam int PS_AG = 0, PS_PRIV = 2, PS_PEF = 4, PS_RED = 5, PS_MG = 10, PS_IG = 11;

  logic [39:0]   st_state [MAXTL+1];
  logic [AW-1:0] st_pc    [MAXTL+1];
  logic [AW-1:0] st_npc   [MAXTL+1];
  logic [8:0]    st_tt    [MAXTL+1];

  logic [TLW-1:0]  tl_q;
  logic [11:0]     ps_q;
  logic [CWPW-1:0] cwp_q;
  logic [AW-1:0]   tbr_q;
  logic            err_q, done_q;

  wire live   = req && !err_q;
  wire accept = live && (tl_q < TLW'(MAXTL));
  wire trip   = live && (tl_q >= TLW'(MAXTL));
  wire go_red = tl_q >= TLW'(MAXTL - 1);
  wire [TLW-1:0] tl_nx = tl_q + 1'b1;

  wire is_ivec  = req_tt == 9'h060;
  wire is_mmu   = req_tt == 9'h008 || req_tt == 9'h030 ||
                  req_tt[8:2] == 7'h19 || req_tt[8:2] == 7'h1a || req_tt[8:2] == 7'h1b;
  wire is_clean = req_tt == 9'h024;
  wire is_spill = req_tt[8:6] == 3'b010;
  wire is_fill  = req_tt[8:6] == 3'b011;

  logic [11:0]     ps_red, ps_nx;
  logic [39:0]     saved;
  logic [CWPW-1:0] cwp_nx;
  logic [7:0]      cwp8;

  always_comb begin
    ps_red = ps_q;
    if (go_red) ps_red[PS_RED] = 1'b1;
    ps_nx = ps_red;
    ps_nx[PS_AG] = 1'b0;
    ps_nx[PS_MG] = 1'b0;
    ps_nx[PS_IG] = 1'b0;
    ps_nx[PS_PRIV] = 1'b1;
    ps_nx[PS_PEF] = 1'b1;
    if (is_ivec)     ps_nx[PS_IG] = 1'b1;
    else if (is_mmu) ps_nx[PS_MG] = 1'b1;
    else             ps_nx[PS_AG] = 1'b1;
  end

  always_comb begin
    cwp8 = 8'(cwp_q);
    saved = {ccr, asi, 4'b0, ps_red[11:8], 2'b0, ps_red[5:0], cwp8};
  end

  always_comb begin
    int w;
    w = int'(cwp_q);
    if (is_clean)      w = (w + NWIN - 1) % NWIN;
    else if (is_spill) w = (w + 2 * NWIN - int'(cansave) - 2) % NWIN;
    else if (is_fill)  w = (w + 1) % NWIN;
    cwp_nx = CWPW'(w);
  end

  wire [14:0] vec_low = {tl_nx > TLW'(1), req_tt, 5'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl_q   <= '0;
      ps_q   <= '0;
      cwp_q  <= '0;
      tbr_q  <= TBA_BASE;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      for (int i = 0; i <= MAXTL; i++) begin
        st_state[i] <= '0;
        st_pc[i]    <= '0;
        st_npc[i]   <= '0;
        st_tt[i]    <= '0;
      end
    end else begin
      done_q <= accept;
      if (trip) err_q <= 1'b1;
      if (accept) begin
        tl_q            <= tl_nx;
        ps_q            <= ps_nx;
        cwp_q           <= cwp_nx;
        tbr_q           <= {tbr_q[AW-1:15], vec_low};
        st_state[tl_nx] <= saved;
        st_pc[tl_nx]    <= cur_pc;
        st_npc[tl_nx]   <= cur_npc;
        st_tt[tl_nx]    <= req_tt;
      end
    end
  end

  assign done     = done_q;
  assign err      = err_q;
  assign tl       = tl_q;
  assign pstate   = ps_q;
  assign cwp      = cwp_q;
  assign tvec_pc  = tbr_q;
  assign tvec_npc = tbr_q + AW'(4);
  assign ts_state = st_state[tl_q];
  assign ts_pc    = st_pc[tl_q];
  assign ts_npc   = st_npc[tl_q];
  assign ts_tt    = st_tt[tl_q];

  AST_TL_STEP: assert property (@(posedge clk) disable iff (!rst_n) done |-> tl == $past(tl) + 1'b1); // R2
  AST_RED_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n) done && ($past(tl) == TLW'(MAXTL - 1)) |-> pstate[PS_RED]); // R3
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) err |=> err && !done && $stable(tl) && $stable(pstate) && $stable(cwp) && $stable(tvec_pc)); // R4
  AST_SAVED_TT: assert property (@(posedge clk) disable iff (!rst_n) done |-> ts_tt == $past(req_tt)); // R6
  AST_ONE_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n) done |-> $countones({pstate[PS_AG], pstate[PS_MG], pstate[PS_IG]}) == 1); // R7
  AST_PRIV_PEF: assert property (@(posedge clk) disable iff (!rst_n) done |-> pstate[PS_PRIV] && pstate[PS_PEF]); // R8
  AST_VEC_TT: assert property (@(posedge clk) disable iff (!rst_n) done |-> tvec_pc[13:5] == ts_tt && tvec_pc[4:0] == 5'b0); // R10
endmodule

// File: tb/tb_trap_entry_seq.sv
`timescale 1ns/1ps
module tb_trap_entry_seq;
  localparam int AW = 64, NWIN = 8, MAXTL = 6, CWPW = 3, TLW = 3;
  localparam logic [63:0] TBA = 64'h40_0000;

  logic clk = 0, rst_n = 0, req = 0;
  logic [8:0] req_tt = 0;
  logic [63:0] cur_pc = 0, cur_npc = 0;
  logic [7:0] ccr = 0, asi = 0;
  logic [2:0] cansave = 0;
  logic done, err;
  logic [TLW-1:0] tl;
  logic [11:0] pstate;
  logic [CWPW-1:0] cwp;
  logic [63:0] tvec_pc, tvec_npc, ts_pc, ts_npc;
  logic [39:0] ts_state;
  logic [8:0] ts_tt;

  always #10 clk = ~clk;

  trap_entry_seq #(.AW(AW), .NWIN(NWIN), .MAXTL(MAXTL), .TBA_BASE(TBA)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_tt(req_tt), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .ccr(ccr), .asi(asi), .cansave(cansave), .done(done), .err(err), .tl(tl), .pstate(pstate),
    .cwp(cwp), .tvec_pc(tvec_pc), .tvec_npc(tvec_npc), .ts_state(ts_state), .ts_pc(ts_pc),
    .ts_npc(ts_npc), .ts_tt(ts_tt));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int m_tl, m_cwp;
  bit m_err, m_done;
  logic [11:0] m_ps;
  logic [63:0] m_tbr;
  logic [39:0] m_st [0:MAXTL];
  logic [63:0] m_pc [0:MAXTL];
  logic [63:0] m_npc [0:MAXTL];
  int m_tt [0:MAXTL];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_tl = 0; m_cwp = 0; m_err = 0; m_done = 0; m_ps = 0; m_tbr = TBA;
    for (int i = 0; i <= MAXTL; i++) begin
      m_st[i] = 0; m_pc[i] = 0; m_npc[i] = 0; m_tt[i] = 0;
    end
  endtask

  task automatic compare_all();
    chk("R2 done", done, m_done);
    chk("R4 err", err, m_err);
    chk("R2 tl", tl, m_tl);
    chk("R7 pstate", pstate, m_ps);
    chk("R9 cwp", cwp, m_cwp);
    chk("R10 tvec_pc", tvec_pc, m_tbr);
    chk("R10 tvec_npc", tvec_npc, m_tbr + 4);
    chk("R5 ts_state", ts_state, m_st[m_tl]);
    chk("R6 ts_pc", ts_pc, m_pc[m_tl]);
    chk("R6 ts_npc", ts_npc, m_npc[m_tl]);
    chk("R6 ts_tt", ts_tt, m_tt[m_tl]);
  endtask

  task automatic predict(bit r, int tt, logic [63:0] pc, logic [63:0] npc, int c, int a, int cs);
    logic [11:0] psr;
    logic [11:0] glob;
    m_done = 0;
    if (r && !m_err) begin
      if (m_tl >= MAXTL) m_err = 1;
      else begin
        psr = m_ps;
        if (m_tl >= MAXTL - 1) psr = psr | 12'h020;
        m_tl = m_tl + 1;
        m_st[m_tl] = 40'((longint'(c) << 32) + (longint'(a) << 24) +
                         (longint'(psr & 12'hf3f) << 8) + longint'(m_cwp));
        m_pc[m_tl] = pc; m_npc[m_tl] = npc; m_tt[m_tl] = tt;
        if (tt == 'h60) glob = 12'h800;
        else if (tt == 'h08 || tt == 'h30 || (tt >= 'h64 && tt <= 'h6f)) glob = 12'h400;
        else glob = 12'h001;
        m_ps = (psr & ~12'hc01) | 12'h014 | glob;
        if (tt == 'h24) m_cwp = (m_cwp + NWIN - 1) % NWIN;
        else if ((tt & 'h1c0) == 'h080) m_cwp = ((m_cwp - cs - 2) % NWIN + NWIN) % NWIN;
        else if ((tt & 'h1c0) == 'h0c0) m_cwp = (m_cwp + 1) % NWIN;
        m_tbr = (m_tbr & ~64'h7fff) | ((m_tl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
        m_done = 1;
      end
    end
  endtask

  task automatic step(bit r, int tt, int cs);
    logic [63:0] pc;
    pc = 64'h1000_0000 + 64'($urandom_range(0, 'hffff)) * 4;
    @(negedge clk);
    compare_all();
    req = r; req_tt = 9'(tt); cur_pc = pc; cur_npc = pc + 4;
    ccr = 8'($urandom_range(0, 255)); asi = 8'($urandom_range(0, 255)); cansave = 3'(cs);
    predict(r, tt, pc, pc + 4, int'(ccr), int'(asi), cs);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  function automatic int pick_tt();
    case ($urandom_range(0, 11))
      0: return 'h060;
      1: return 'h008;
      2: return 'h030;
      3: return 'h064 + $urandom_range(0, 11);
      4: return 'h024;
      5: return 'h080 + $urandom_range(0, 63);
      6: return 'h0c0 + $urandom_range(0, 63);
      default: return $urandom_range(0, 511);
    endcase
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 tl", tl, 0);
    chk("R1 pstate", pstate, 0);
    chk("R1 cwp", cwp, 0);
    chk("R1 err", err, 0);
    chk("R1 done", done, 0);
    chk("R1 tvec_pc", tvec_pc, TBA);
    chk("R1 tvec_npc", tvec_npc, TBA + 4);
    chk("R1 ts_state", ts_state, 0);
    chk("R1 ts_pc", ts_pc, 0);

    step(1, 'h060, 0);
    step(0, 0, 0);
    chk("R8 priv/pef", {62'b0, pstate[2], pstate[4]}, 3);
    step(1, 'h024, 0);
    step(1, 'h0a3, 3);
    step(1, 'h0c7, 0);
    step(1, 'h069, 0);
    step(1, 'h030, 0);
    step(0, 0, 0);
    chk("R3 red bit", pstate[5], 1);
    chk("R3 tl at top", tl, MAXTL);
    step(1, 'h008, 0);
    step(1, 'h060, 0);
    step(1, 'h024, 0);
    step(0, 0, 0);
    chk("R4 err sticky", err, 1);
    chk("R4 tl frozen", tl, MAXTL);

    for (int k = 0; k < 40; k++) begin
      do_reset();
      for (int j = 0; j < 60; j++) begin
        step($urandom_range(0, 2) != 0, pick_tt(), $urandom_range(0, NWIN - 1));
      end
      step(0, 0, 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule